// File: doc/BRIEF.md
# Interval Timer Host Register Port

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a 2-bit address. Addresses 0, 1 and 2 are the data ports of the channels with those numbers, and address 3 takes control words. Each channel keeps a configuration in the block: how its 16-bit count is transferred over the byte bus, its counting mode and its BCD flag. The counting mode and the BCD flag are passed on to the channel cores.

Host byte writes to a data port are assembled into a 16-bit count. The assembled count goes to the channel core as a one-cycle load strobe with the value beside it. A value of zero is passed through unchanged. Reads of a data port return one of three things: a captured status byte, a captured (frozen) count, or the live count that the channel core supplies. Control words can freeze a channel's count, and a read-back command can capture count and/or status for any set of channels at once. The counting itself lives in the channel cores, outside this block.

Top module: `tmr_host_port`

## Requirements
- R1: After reset every channel has transfer format 3 (low then high byte), counting mode 3 and BCD 0. No capture is pending and both byte toggles point at the low byte.
- R2: A write to address 3 whose bits 7:6 give a channel number 0..2 and whose bits 5:4 are nonzero sets that channel's transfer format from bits 5:4, its counting mode (`chan_mode`) from bits 3:1 and its BCD flag (`chan_bcd`) from bit 0. The write also returns both byte toggles of that channel to the low byte.
- R3: With format 1 (low byte only), a data write pulses that channel's `load_stb` for exactly the cycle after the write, with `load_val` = {8'h00, byte}. A load strobe only ever follows a data write to that same channel.
- R4: With format 2 (high byte only), a data write loads {byte, 8'h00}.
- R5: With format 3, the first data write loads nothing and is held. The second write loads {second, first}, and the channel then expects a low byte again.
- R6: A control word with bits 5:4 = 0 (count capture) freezes the channel's live count and leaves its format, mode and BCD unchanged. Reads then return the frozen bytes in the order the format dictates, and after that the live count.
- R7: A count capture request for a channel whose frozen count has not been completely read is ignored.
- R8: A control word with bits 7:6 = 3 is a read-back command. Bit 1 selects channel 0, bit 2 channel 1 and bit 3 channel 2. For each selected channel, a low bit 5 captures the count (under the rule of R7) and a low bit 4 captures status. Status is captured only if no earlier status byte is still unread.
- R9: The status byte holds the channel output level in bit 7, 0 in bit 6, the transfer format in bits 5:4, the counting mode in bits 3:1 and BCD in bit 0. All fields are sampled when the command is accepted.
- R10: A data read returns a pending status byte before a pending frozen count, and a pending frozen count before the live count. Reading a status byte clears it. A frozen count is cleared once all of its bytes have been read.
- R11: With format 3, reads return the low byte then the high byte. The read toggle is independent of the write toggle.
- R12: A read from address 3 returns 0 and changes no state. A control word never produces a load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0..2 channel data, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte; side effects at the clock edge |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid combinationally while `bus_rd` is high |
| live_cnt | input | 3*16 | Live count of each channel core, channel 0 in the low bits |
| chan_out | input | 3 | Output level of each channel core |
| load_stb | output | 3 | One-cycle count load strobe per channel |
| load_val | output | 3*16 | Count value per channel, valid with `load_stb` |
| chan_mode | output | 3*3 | Counting mode per channel |
| chan_bcd | output | 3 | BCD flag per channel |

## Verification
The bench goes after the toggle corners. A write half-done in word format, followed by a fresh control word, must restart at the low byte. A design that kept the toggle would assemble the wrong count. The bench also interleaves reads inside a pending write pair, which exposes a design that shares one toggle between reads and writes. It repeats count captures while a frozen count is half-read and repeats status captures while a status byte is unread; a design that recaptured would return the newer values. Read-back of several channels at once, the priority of status over frozen count, and a read at address 3 in the middle of a word read are checked against the read order that should result.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;

   typedef enum logic [1:0] {
      XFER_CAPTURE = 2'd0,
      XFER_LO      = 2'd1,
      XFER_HI      = 2'd2,
      XFER_WORD    = 2'd3
   } xfer_e;

   localparam logic [1:0] SEL_READBACK = 2'd3;
   localparam int         BYTE_W       = 8;

   typedef struct packed {
      logic       out_lvl;
      logic       rsvd;
      xfer_e      xfer;
      logic [2:0] mode;
      logic       bcd;
   } status_t;

endpackage

// File: rtl/tmr_cw_decode.sv
module tmr_cw_decode
   import tmr_host_pkg::*;
#(
   parameter int NCH = 3
) (
   input  logic           wr_en,
   input  logic           rd_en,
   input  logic [1:0]     addr,
   input  logic [7:1]     wdata,
   output logic [NCH-1:0] cfg_wr,
   output logic [NCH-1:0] cnt_cap,
   output logic [NCH-1:0] sts_cap,
   output logic [NCH-1:0] data_wr,
   output logic [NCH-1:0] data_rd
);

   logic       is_ctl;
   logic [1:0] sel;
   logic [1:0] xfer;

   assign is_ctl = wr_en && (addr == SEL_READBACK);
   assign sel    = wdata[7:6];
   assign xfer   = wdata[5:4];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic direct;
      logic rback;
      assign direct     = is_ctl && (sel == 2'(i));
      assign rback      = is_ctl && (sel == SEL_READBACK) && wdata[i+1];
      assign cfg_wr[i]  = direct && (xfer != XFER_CAPTURE);
      assign cnt_cap[i] = (direct && (xfer == XFER_CAPTURE)) || (rback && !wdata[5]);
      assign sts_cap[i] = rback && !wdata[4];
      assign data_wr[i] = wr_en && (addr == 2'(i));
      assign data_rd[i] = rd_en && (addr == 2'(i));
   end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
   import tmr_host_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic          cnt_cap,
   input  logic          sts_cap,
   input  logic          data_wr,
   input  logic          data_rd,
   input  logic [7:0]    wbyte,
   input  logic [CW-1:0] live,
   input  logic          out_lvl,
   output xfer_e         xfer,
   output logic [2:0]    mode,
   output logic          bcd,
   output logic          load_stb,
   output logic [CW-1:0] load_val,
   output logic [7:0]    rd_byte
);

   localparam int BW = CW / 2;

   xfer_e         xfer_q;
   logic [2:0]    mode_q;
   logic          bcd_q;
   logic          wr_hi_q;
   logic          rd_hi_q;
   logic [BW-1:0] wlo_q;
   xfer_e         cap_q;      // XFER_CAPTURE here means nothing frozen
   logic [CW-1:0] cap_val_q;
   logic          sts_vld_q;
   status_t       sts_q;
   logic          ld_q;
   logic [CW-1:0] ld_val_q;

   logic [BW-1:0] cap_lo, cap_hi, live_lo, live_hi;
   assign cap_lo  = cap_val_q[BW-1:0];
   assign cap_hi  = cap_val_q[CW-1:BW];
   assign live_lo = live[BW-1:0];
   assign live_hi = live[CW-1:BW];

   always_comb begin
      if (sts_vld_q) begin
         rd_byte = sts_q;
      end else if (cap_q != XFER_CAPTURE) begin
         rd_byte = (cap_q == XFER_HI) ? cap_hi : cap_lo;
      end else begin
         unique case (xfer_q)
            XFER_HI:   rd_byte = live_hi;
            XFER_WORD: rd_byte = rd_hi_q ? live_hi : live_lo;
            default:   rd_byte = live_lo;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_q    <= XFER_WORD;
         mode_q    <= 3'd3;
         bcd_q     <= 1'b0;
         wr_hi_q   <= 1'b0;
         rd_hi_q   <= 1'b0;
         wlo_q     <= '0;
         cap_q     <= XFER_CAPTURE;
         cap_val_q <= '0;
         sts_vld_q <= 1'b0;
         sts_q     <= '0;
         ld_q      <= 1'b0;
         ld_val_q  <= '0;
      end else begin
         ld_q <= 1'b0;
         if (cfg_wr) begin
            xfer_q  <= xfer_e'(wbyte[5:4]);
            mode_q  <= wbyte[3:1];
            bcd_q   <= wbyte[0];
            wr_hi_q <= 1'b0;
            rd_hi_q <= 1'b0;
         end else if (data_wr) begin
            unique case (xfer_q)
               XFER_HI: begin
                  ld_q     <= 1'b1;
                  ld_val_q <= {wbyte, {BW{1'b0}}};
               end
               XFER_WORD: begin
                  if (!wr_hi_q) begin
                     wlo_q   <= wbyte;
                     wr_hi_q <= 1'b1;
                  end else begin
                     ld_q     <= 1'b1;
                     ld_val_q <= {wbyte, wlo_q};
                     wr_hi_q  <= 1'b0;
                  end
               end
               default: begin
                  ld_q     <= 1'b1;
                  ld_val_q <= {{BW{1'b0}}, wbyte};
               end
            endcase
         end
         if (data_rd) begin
            if (sts_vld_q) begin
               sts_vld_q <= 1'b0;
            end else if (cap_q != XFER_CAPTURE) begin
               cap_q <= (cap_q == XFER_WORD) ? XFER_HI : XFER_CAPTURE;
            end else if (xfer_q == XFER_WORD) begin
               rd_hi_q <= !rd_hi_q;
            end
         end
         if (cnt_cap && (cap_q == XFER_CAPTURE)) begin
            cap_val_q <= live;
            cap_q     <= xfer_q;
         end
         if (sts_cap && !sts_vld_q) begin
            sts_q     <= '{out_lvl: out_lvl, rsvd: 1'b0, xfer: xfer_q,
                           mode: mode_q, bcd: bcd_q};
            sts_vld_q <= 1'b1;
         end
      end
   end

   assign xfer     = xfer_q;
   assign mode     = mode_q;
   assign bcd      = bcd_q;
   assign load_stb = ld_q;
   assign load_val = ld_val_q;

endmodule

// File: rtl/tmr_rd_select.sv
module tmr_rd_select #(
   parameter int NCH = 3
) (
   input  logic [1:0]           addr,
   input  logic [NCH-1:0][7:0]  ch_bytes,
   output logic [7:0]           rdata
);

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (addr == 2'(i)) rdata = ch_bytes[i];
      end
   end

endmodule

// File: rtl/tmr_host_port.sv
module tmr_host_port
   import tmr_host_pkg::*;
#(
   parameter int NCH = 3,
   parameter int CW  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   input  logic [NCH*CW-1:0]  live_cnt,
   input  logic [NCH-1:0]     chan_out,
   output logic [NCH-1:0]     load_stb,
   output logic [NCH*CW-1:0]  load_val,
   output logic [NCH*3-1:0]   chan_mode,
   output logic [NCH-1:0]     chan_bcd
);

   if (NCH < 1 || NCH > 3) begin : g_bad_nch
      $error("tmr_host_port: NCH must be 1..3, address 3 is the control port");
   end
   if (CW != 2 * BYTE_W) begin : g_bad_cw
      $error("tmr_host_port: CW must be two bus bytes");
   end

   logic [NCH-1:0]       cfg_wr, cnt_cap, sts_cap, data_wr, data_rd;
   logic [NCH-1:0][7:0]  ch_bytes;
   logic [2*NCH-1:0]     xfer_bus;

   tmr_cw_decode #(.NCH(NCH)) u_dec (
      .wr_en   (bus_wr),
      .rd_en   (bus_rd),
      .addr    (bus_addr),
      .wdata   (bus_wdata[7:1]),
      .cfg_wr  (cfg_wr),
      .cnt_cap (cnt_cap),
      .sts_cap (sts_cap),
      .data_wr (data_wr),
      .data_rd (data_rd)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      xfer_e xf;
      tmr_chan_regs #(.CW(CW)) u_regs (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_wr   (cfg_wr[i]),
         .cnt_cap  (cnt_cap[i]),
         .sts_cap  (sts_cap[i]),
         .data_wr  (data_wr[i]),
         .data_rd  (data_rd[i]),
         .wbyte    (bus_wdata),
         .live     (live_cnt[i*CW +: CW]),
         .out_lvl  (chan_out[i]),
         .xfer     (xf),
         .mode     (chan_mode[i*3 +: 3]),
         .bcd      (chan_bcd[i]),
         .load_stb (load_stb[i]),
         .load_val (load_val[i*CW +: CW]),
         .rd_byte  (ch_bytes[i])
      );
      assign xfer_bus[2*i +: 2] = xf;
   end

   tmr_rd_select #(.NCH(NCH)) u_rsel (
      .addr     (bus_addr),
      .ch_bytes (ch_bytes),
      .rdata    (bus_rdata)
   );

endmodule

// File: rtl/tmr_host_port_chk.sv
module tmr_host_port_chk #(
   parameter int NCH = 3,
   parameter int CW  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [7:0]        bus_rdata,
   input logic [NCH-1:0]    load_stb,
   input logic [NCH*CW-1:0] load_val,
   input logic [2*NCH-1:0]  xfer_bus
);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      p_load_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
         load_stb[i] |-> ($past(bus_wr) && ($past(bus_addr) == 2'(i))));

      p_lo_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (load_stb[i] && ($past(xfer_bus[2*i +: 2]) == 2'd1))
            |-> (load_val[i*CW + CW/2 +: CW/2] == '0));

      p_hi_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (load_stb[i] && ($past(xfer_bus[2*i +: 2]) == 2'd2))
            |-> (load_val[i*CW +: CW/2] == '0));
   end

   p_ctl_no_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wr && (bus_addr == 2'd3)) |-> (load_stb == '0));

   p_ctl_read_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == 2'd3)) |-> (bus_rdata == 8'h00));

endmodule

bind tmr_host_port tmr_host_port_chk #(.NCH(NCH), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .load_stb  (load_stb),
   .load_val  (load_val),
   .xfer_bus  (xfer_bus)
);

// File: tb/tmr_host_port_test.sv
module tmr_host_port_test;

   localparam int NCH = 3;
   localparam int CW  = 16;

   typedef struct { logic [7:0] val; string tag; } rd_item_t;
   typedef struct { int ch; logic [15:0] val; string tag; } ld_item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [7:0]        bus_wdata = '0;
   logic [7:0]        bus_rdata;
   logic [NCH*CW-1:0] live_cnt;
   logic [NCH-1:0]    chan_out = 3'b101;
   logic [NCH-1:0]    load_stb;
   logic [NCH*CW-1:0] load_val;
   logic [NCH*3-1:0]  chan_mode;
   logic [NCH-1:0]    chan_bcd;

   rd_item_t rd_q[$];
   ld_item_t ld_q[$];
   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tmr_host_port #(.NCH(NCH), .CW(CW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .live_cnt(live_cnt), .chan_out(chan_out), .load_stb(load_stb),
      .load_val(load_val), .chan_mode(chan_mode), .chan_bcd(chan_bcd)
   );

   task automatic set_live(input int ch, input logic [15:0] v);
      live_cnt[ch*CW +: CW] = v;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr_ld(input int ch, input logic [7:0] d,
                        input logic [15:0] exp, input string tag);
      ld_item_t it;
      it.ch = ch; it.val = exp; it.tag = tag;
      ld_q.push_back(it);
      wr(2'(ch), d);
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      rd_item_t it;
      it.val = exp; it.tag = tag;
      rd_q.push_back(it);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard queues as the design produces results.
   always @(negedge clk) begin
      #5;
      if (rst_n && !done) begin
         if (bus_rd) begin
            compared++;
            if (rd_q.size() == 0) begin
               mismatched++;
               $display("FAIL R10: actual read %h expected no read", bus_rdata);
            end else begin
               rd_item_t e;
               e = rd_q.pop_front();
               if (bus_rdata !== e.val) begin
                  mismatched++;
                  $display("FAIL %s: actual read %h expected %h", e.tag, bus_rdata, e.val);
               end
            end
         end
         for (int c = 0; c < NCH; c++) begin
            if (load_stb[c]) begin
               compared++;
               if (ld_q.size() == 0) begin
                  mismatched++;
                  $display("FAIL R12: actual load ch%0d %h expected none", c,
                           load_val[c*CW +: CW]);
               end else begin
                  ld_item_t e;
                  e = ld_q.pop_front();
                  if (e.ch != c || load_val[c*CW +: CW] !== e.val) begin
                     mismatched++;
                     $display("FAIL %s: actual load ch%0d %h expected ch%0d %h",
                              e.tag, c, load_val[c*CW +: CW], e.ch, e.val);
                  end
               end
            end
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      set_live(0, 16'h1234); set_live(1, 16'hABCD); set_live(2, 16'h0F0E);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset configuration
      chk(8'(chan_mode), 8'(9'b011_011_011), "R1 mode");
      chk(8'(chan_bcd), 8'h00, "R1 bcd");
      chk(8'(load_stb), 8'h00, "R1 load_stb");
      rd(2'd0, 8'h34, "R1/R11 lo"); rd(2'd0, 8'h12, "R1/R11 hi");

      // R2/R3: ch0 low-only, mode 2
      wr(2'd3, 8'h14);
      chk(8'(chan_mode[2:0]), 8'd2, "R2 ch0 mode");
      wr_ld(0, 8'h5A, 16'h005A, "R3");
      rd(2'd0, 8'h34, "R3 read lo"); rd(2'd0, 8'h34, "R3 read lo again");

      // R4: ch1 high-only, mode 0, BCD
      wr(2'd3, 8'h61);
      chk(8'(chan_bcd[1]), 8'd1, "R2 ch1 bcd");
      chk(8'(chan_mode[5:3]), 8'd0, "R2 ch1 mode");
      wr_ld(1, 8'h77, 16'h7700, "R4");
      rd(2'd1, 8'hAB, "R4 read hi");

      // R5: ch2 word format, mode 4
      wr(2'd3, 8'hB8);
      chk(8'(chan_mode[8:6]), 8'd4, "R2 ch2 mode");
      wr(2'd2, 8'h11);                      // R5: first byte held, no load
      wr_ld(2, 8'h22, 16'h2211, "R5 pair1");
      wr(2'd2, 8'h33);
      wr_ld(2, 8'h44, 16'h4433, "R5 pair2");
      // R11: reads inside a pending write pair
      wr(2'd2, 8'h55);
      rd(2'd2, 8'h0E, "R11 lo"); rd(2'd2, 8'h0F, "R11 hi");
      wr_ld(2, 8'h66, 16'h6655, "R11 write toggle kept");
      // R2: control word restarts write and read toggles
      wr(2'd2, 8'h99);
      wr(2'd3, 8'hB8);
      wr(2'd2, 8'h01);
      wr_ld(2, 8'h02, 16'h0201, "R2 write toggle reset");
      rd(2'd2, 8'h0E, "R2 read lo");
      wr(2'd3, 8'hB8);
      rd(2'd2, 8'h0E, "R2 read toggle reset");
      rd(2'd2, 8'h0F, "R11 realign");

      // R6: count capture on ch2
      wr(2'd3, 8'h80);
      chk(8'(chan_mode[8:6]), 8'd4, "R6 mode kept");
      set_live(2, 16'h5555);
      rd(2'd2, 8'h0E, "R6 frozen lo"); rd(2'd2, 8'h0F, "R6 frozen hi");
      rd(2'd2, 8'h55, "R6 live lo");   rd(2'd2, 8'h55, "R6 live hi");

      // R7: capture ignored while pending
      wr(2'd3, 8'h80);
      set_live(2, 16'h7777);
      wr(2'd3, 8'h80);
      rd(2'd2, 8'h55, "R7 lo kept");
      wr(2'd3, 8'h80);
      set_live(2, 16'h8888);
      rd(2'd2, 8'h55, "R7 hi kept");
      rd(2'd2, 8'h88, "R7 live lo"); rd(2'd2, 8'h88, "R7 live hi");

      // R8/R9/R10: read-back ch1, count and status
      wr(2'd3, 8'hC4);
      set_live(1, 16'h1357);
      rd(2'd1, 8'h21, "R9 status ch1");
      rd(2'd1, 8'hAB, "R10 frozen after status");
      rd(2'd1, 8'h13, "R10 live after frozen");

      // R8: status-only read-back ch0, not overwritten while unread
      wr(2'd3, 8'hE2);
      chan_out[0] = 1'b0;
      wr(2'd3, 8'hE2);
      rd(2'd0, 8'h94, "R8 status kept");
      rd(2'd0, 8'h34, "R8 no count captured");
      wr(2'd3, 8'hE2);
      rd(2'd0, 8'h14, "R9 new out level");

      // R8: count-only read-back of all channels
      set_live(0, 16'h4321); set_live(1, 16'h2468); set_live(2, 16'h4E2D);
      wr(2'd3, 8'hDE);
      set_live(0, 16'h0000); set_live(1, 16'h0000); set_live(2, 16'h0000);
      rd(2'd0, 8'h21, "R8 ch0 frozen");
      rd(2'd0, 8'h00, "R8 ch0 live");
      rd(2'd2, 8'h2D, "R8 ch2 lo"); rd(2'd2, 8'h4E, "R8 ch2 hi");
      rd(2'd1, 8'h24, "R8 ch1 hi");
      rd(2'd1, 8'h00, "R8 ch1 live");
      rd(2'd2, 8'h00, "R11 live lo");

      // R12: address-3 read is zero and leaves the read toggle alone
      set_live(2, 16'hA1B2);
      rd(2'd3, 8'h00, "R12 zero");
      rd(2'd2, 8'hA1, "R12 toggle untouched");
      rd(2'd2, 8'hB2, "R12 next lo");

      repeat (4) @(negedge clk);
      compared++;
      if (rd_q.size() != 0 || ld_q.size() != 0) begin
         mismatched++;
         $display("FAIL R3: actual %0d/%0d pending expected 0/0", rd_q.size(), ld_q.size());
      end
      finish_run();
   end

endmodule